// File: doc/BRIEF.md
# ALU Operand Bypass Selector

This block picks the operands that the execute stage of a five-stage in-order pipeline feeds to its ALU. It also picks the data that a store sends to memory. Each operand is named by a register specifier. The block compares that specifier with the destinations of the three instructions further down the pipe. Those instructions sit in the execute/memory register, in the memory/writeback register, and in a holding register that keeps the value written back one cycle earlier. When one of them will write the register the operand reads, its result replaces the value read from the register file.

Each downstream slot carries an opcode class. Only instructions that write a register take part. An ALU result can be bypassed from any of the three slots. A loaded value only exists once the memory access has finished, so the execute/memory slot never supplies it. When several slots match, the youngest producer wins. The selection is purely combinational. Stalling on a load whose data is not yet ready belongs to the interlock logic, not to this block.

Top module: `alu_bypass_unit`

## Requirements
- R1: An operand whose specifier matches no eligible downstream destination takes its register-file value.
- R2: When the execute/memory slot holds an ALU op (class 3'd1) whose destination equals an operand's specifier, that operand takes the execute/memory result.
- R3: A load (class 3'd2) in the execute/memory slot is never a bypass source. The operand falls through to the older slots or to the register file.
- R4: The memory/writeback slot supplies its result to a matching operand when it holds an ALU op or a load, and no eligible execute/memory match exists.
- R5: The writeback holding slot supplies its result to a matching operand when it holds an ALU op or a load, and neither younger slot has an eligible match.
- R6: When several slots match, the priority is execute/memory, then memory/writeback, then writeback holding, then the register file.
- R7: Slots holding a no-op (3'd0), a store (3'd3) or a branch (3'd4) never affect any operand, whatever their destination field holds.
- R8: ALU operand A, ALU operand B and the store data operand are each resolved independently under R1 to R7, using their own specifier and their own register-file value.
- R9: The operands follow their inputs combinationally, with no clock and no storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | REG_W | Specifier of ALU operand A |
| src_b | input | REG_W | Specifier of ALU operand B |
| src_sd | input | REG_W | Specifier of the store data operand |
| rf_a | input | DATA_W | Register-file value for operand A |
| rf_b | input | DATA_W | Register-file value for operand B |
| rf_sd | input | DATA_W | Register-file value for the store data |
| exm_op | input | 3 | Opcode class in the execute/memory slot |
| exm_dest | input | REG_W | Destination in the execute/memory slot |
| exm_val | input | DATA_W | ALU result in the execute/memory slot |
| mwb_op | input | 3 | Opcode class in the memory/writeback slot |
| mwb_dest | input | REG_W | Destination in the memory/writeback slot |
| mwb_val | input | DATA_W | Result (ALU or load) in the memory/writeback slot |
| wbh_op | input | 3 | Opcode class in the writeback holding slot |
| wbh_dest | input | REG_W | Destination in the writeback holding slot |
| wbh_val | input | DATA_W | Value held from the last writeback |
| opnd_a | output | DATA_W | Selected ALU operand A |
| opnd_b | output | DATA_W | Selected ALU operand B |
| store_data | output | DATA_W | Selected store data |

## Verification
All three results are due in the same cycle as the stimulus, because no register lies between any input and any output. The bench applies each input pattern at a rising edge and reads the outputs at the next falling edge, half a period later, so every value has settled. The sweep covers every combination of opcode class in the three slots, every destination over a reduced register range, and rotating specifiers for the three operands. Each comparison is tagged with the requirement that decides its expected value.

// File: rtl/alu_bypass_pkg.sv
package alu_bypass_pkg;

  localparam int OPC_W    = 3;
  localparam int NUM_SRC  = 3;  // 0: exe/mem, 1: mem/wb, 2: wb holding
  localparam int NUM_OPND = 3;  // 0: operand A, 1: operand B, 2: store data
  localparam int SEL_W    = 2;

  typedef enum logic [OPC_W-1:0] {
    OPC_NOP    = 3'd0,
    OPC_ALU    = 3'd1,
    OPC_LOAD   = 3'd2,
    OPC_STORE  = 3'd3,
    OPC_BRANCH = 3'd4
  } opc_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_RF  = 2'd0,
    SEL_EXM = 2'd1,
    SEL_MWB = 2'd2,
    SEL_WBH = 2'd3
  } sel_e;

  // A slot may feed an operand if it writes a register and its value is
  // already present there; loads only count once memory has answered.
  function automatic logic slot_eligible(input logic [OPC_W-1:0] op,
                                         input logic load_ready);
    return (op == OPC_ALU) || (load_ready && (op == OPC_LOAD));
  endfunction

  // Youngest producer first.
  function automatic sel_e pick_source(input logic [NUM_SRC-1:0] hit);
    if (hit[0])      return SEL_EXM;
    else if (hit[1]) return SEL_MWB;
    else if (hit[2]) return SEL_WBH;
    else             return SEL_RF;
  endfunction

endpackage

// File: rtl/bypass_slot_match.sv
module bypass_slot_match
  import alu_bypass_pkg::*;
#(
  parameter int REG_W      = 3,
  parameter bit LOAD_READY = 1'b1
) (
  input  logic [OPC_W-1:0]          op,
  input  logic [REG_W-1:0]          dest,
  input  logic [NUM_OPND*REG_W-1:0] srcs,
  output logic [NUM_OPND-1:0]       hit
);

  logic eligible;
  assign eligible = slot_eligible(op, LOAD_READY);

  for (genvar o = 0; o < NUM_OPND; o++) begin : g_opnd
    assign hit[o] = eligible && (dest == srcs[o*REG_W +: REG_W]);
  end

endmodule

// File: rtl/bypass_operand_mux.sv
module bypass_operand_mux
  import alu_bypass_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [NUM_SRC-1:0] hit,
  input  logic [DATA_W-1:0]  rf_val,
  input  logic [DATA_W-1:0]  exm_val,
  input  logic [DATA_W-1:0]  mwb_val,
  input  logic [DATA_W-1:0]  wbh_val,
  output logic [SEL_W-1:0]   sel,
  output logic [DATA_W-1:0]  data
);

  sel_e choice;
  assign choice = pick_source(hit);
  assign sel    = choice;

  always_comb begin
    unique case (choice)
      SEL_EXM: data = exm_val;
      SEL_MWB: data = mwb_val;
      SEL_WBH: data = wbh_val;
      default: data = rf_val;
    endcase
  end

endmodule

// File: rtl/alu_bypass_unit.sv
module alu_bypass_unit
  import alu_bypass_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 3
) (
  input  logic [REG_W-1:0]  src_a,
  input  logic [REG_W-1:0]  src_b,
  input  logic [REG_W-1:0]  src_sd,
  input  logic [DATA_W-1:0] rf_a,
  input  logic [DATA_W-1:0] rf_b,
  input  logic [DATA_W-1:0] rf_sd,
  input  logic [2:0]        exm_op,
  input  logic [REG_W-1:0]  exm_dest,
  input  logic [DATA_W-1:0] exm_val,
  input  logic [2:0]        mwb_op,
  input  logic [REG_W-1:0]  mwb_dest,
  input  logic [DATA_W-1:0] mwb_val,
  input  logic [2:0]        wbh_op,
  input  logic [REG_W-1:0]  wbh_dest,
  input  logic [DATA_W-1:0] wbh_val,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] store_data
);

  localparam int SRC_BUS_W  = NUM_OPND * REG_W;
  localparam int DATA_BUS_W = NUM_OPND * DATA_W;

  // Flattened views so that sources and operands can be generated.
  logic [SRC_BUS_W-1:0]          spec_bus;
  logic [DATA_BUS_W-1:0]         rf_bus;
  logic [DATA_BUS_W-1:0]         out_bus;
  logic [NUM_SRC*OPC_W-1:0]      slot_op;
  logic [NUM_SRC*REG_W-1:0]      slot_dest;

  // Named internal events for the checker.
  logic [NUM_SRC-1:0]            slot_hit [NUM_OPND];
  logic [NUM_OPND*SEL_W-1:0]     opnd_sel;

  assign spec_bus  = {src_sd, src_b, src_a};
  assign rf_bus    = {rf_sd, rf_b, rf_a};
  assign slot_op   = {wbh_op, mwb_op, exm_op};
  assign slot_dest = {wbh_dest, mwb_dest, exm_dest};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
    logic [NUM_OPND-1:0] hit_by_opnd;
    bypass_slot_match #(
      .REG_W      (REG_W),
      .LOAD_READY (s != 0)
    ) u_match (
      .op   (slot_op[s*OPC_W +: OPC_W]),
      .dest (slot_dest[s*REG_W +: REG_W]),
      .srcs (spec_bus),
      .hit  (hit_by_opnd)
    );
    for (genvar o = 0; o < NUM_OPND; o++) begin : g_fan
      assign slot_hit[o][s] = hit_by_opnd[o];
    end
  end

  for (genvar o = 0; o < NUM_OPND; o++) begin : g_opnd
    bypass_operand_mux #(
      .DATA_W (DATA_W)
    ) u_mux (
      .hit     (slot_hit[o]),
      .rf_val  (rf_bus[o*DATA_W +: DATA_W]),
      .exm_val (exm_val),
      .mwb_val (mwb_val),
      .wbh_val (wbh_val),
      .sel     (opnd_sel[o*SEL_W +: SEL_W]),
      .data    (out_bus[o*DATA_W +: DATA_W])
    );
  end

  assign opnd_a     = out_bus[0*DATA_W +: DATA_W];
  assign opnd_b     = out_bus[1*DATA_W +: DATA_W];
  assign store_data = out_bus[2*DATA_W +: DATA_W];

endmodule

// File: rtl/alu_bypass_checker.sv
module alu_bypass_checker #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 3
) (
  input logic [REG_W-1:0]  src_a,
  input logic [REG_W-1:0]  src_sd,
  input logic [DATA_W-1:0] rf_a,
  input logic [DATA_W-1:0] rf_b,
  input logic [DATA_W-1:0] rf_sd,
  input logic [2:0]        exm_op,
  input logic [REG_W-1:0]  exm_dest,
  input logic [DATA_W-1:0] exm_val,
  input logic [2:0]        mwb_op,
  input logic [REG_W-1:0]  mwb_dest,
  input logic [DATA_W-1:0] mwb_val,
  input logic [2:0]        wbh_op,
  input logic [REG_W-1:0]  wbh_dest,
  input logic [DATA_W-1:0] wbh_val,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [DATA_W-1:0] store_data,
  input logic [5:0]        opnd_sel
);

  // Independent view of which slots really produce for operand A.
  logic exm_writes, mwb_writes, wbh_writes;
  logic a_exm, a_mwb, a_wbh, sd_exm;
  logic none_writes;

  assign exm_writes  = (exm_op == 3'd1);
  assign mwb_writes  = (mwb_op == 3'd1) || (mwb_op == 3'd2);
  assign wbh_writes  = (wbh_op == 3'd1) || (wbh_op == 3'd2);
  assign a_exm       = exm_writes && (exm_dest == src_a);
  assign a_mwb       = mwb_writes && (mwb_dest == src_a);
  assign a_wbh       = wbh_writes && (wbh_dest == src_a);
  assign sd_exm      = exm_writes && (exm_dest == src_sd);
  assign none_writes = !exm_writes && !mwb_writes && !wbh_writes;

  always_comb begin
    if (!a_exm && !a_mwb && !a_wbh)
      AST_NO_MATCH_USES_RF: assert (opnd_a == rf_a); // R1
    if (a_exm)
      AST_EXM_ALU_FORWARDED: assert (opnd_a == exm_val); // R2
    if (exm_op == 3'd2 && exm_dest == src_a && exm_val != rf_a &&
        exm_val != mwb_val && exm_val != wbh_val)
      AST_LOAD_NOT_FROM_EXM: assert (opnd_a != exm_val); // R3
    if (!a_exm && a_mwb)
      AST_MWB_FORWARDED: assert (opnd_a == mwb_val); // R4
    if (!a_exm && !a_mwb && a_wbh)
      AST_WBH_FORWARDED: assert (opnd_a == wbh_val); // R5
    if (a_exm && a_mwb && a_wbh)
      AST_YOUNGEST_WINS: assert (opnd_sel[1:0] == 2'd1); // R6
    if (none_writes)
      AST_IGNORED_SLOTS: assert (opnd_a == rf_a && opnd_b == rf_b && store_data == rf_sd); // R7
    if (sd_exm)
      AST_STORE_DATA_BYPASS: assert (store_data == exm_val && opnd_sel[5:4] == 2'd1); // R8
  end

endmodule

bind alu_bypass_unit alu_bypass_checker #(
  .DATA_W (DATA_W),
  .REG_W  (REG_W)
) u_bypass_chk (
  .src_a      (src_a),
  .src_sd     (src_sd),
  .rf_a       (rf_a),
  .rf_b       (rf_b),
  .rf_sd      (rf_sd),
  .exm_op     (exm_op),
  .exm_dest   (exm_dest),
  .exm_val    (exm_val),
  .mwb_op     (mwb_op),
  .mwb_dest   (mwb_dest),
  .mwb_val    (mwb_val),
  .wbh_op     (wbh_op),
  .wbh_dest   (wbh_dest),
  .wbh_val    (wbh_val),
  .opnd_a     (opnd_a),
  .opnd_b     (opnd_b),
  .store_data (store_data),
  .opnd_sel   (opnd_sel)
);

// File: tb/alu_bypass_unit_test.sv
module alu_bypass_unit_test;

  localparam int DW = 32;
  localparam int RW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic [RW-1:0] src_a = '0, src_b = '0, src_sd = '0;
  logic [DW-1:0] rf_a = '0, rf_b = '0, rf_sd = '0;
  logic [2:0]    exm_op = '0, mwb_op = '0, wbh_op = '0;
  logic [RW-1:0] exm_dest = '0, mwb_dest = '0, wbh_dest = '0;
  logic [DW-1:0] exm_val = '0, mwb_val = '0, wbh_val = '0;
  logic [DW-1:0] opnd_a, opnd_b, store_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  alu_bypass_unit #(.DATA_W(DW), .REG_W(RW)) uut (
    .src_a(src_a), .src_b(src_b), .src_sd(src_sd),
    .rf_a(rf_a), .rf_b(rf_b), .rf_sd(rf_sd),
    .exm_op(exm_op), .exm_dest(exm_dest), .exm_val(exm_val),
    .mwb_op(mwb_op), .mwb_dest(mwb_dest), .mwb_val(mwb_val),
    .wbh_op(wbh_op), .wbh_dest(wbh_dest), .wbh_val(wbh_val),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .store_data(store_data)
  );

  // Expected operand: start at the register file and let each older-to-
  // younger producer overwrite it; a load counts only past memory.
  function automatic logic [DW-1:0] model(input logic [RW-1:0] s,
                                          input logic [DW-1:0] rf);
    logic [DW-1:0] v = rf;
    if ((wbh_op == 3'd1 || wbh_op == 3'd2) && wbh_dest == s) v = wbh_val;
    if ((mwb_op == 3'd1 || mwb_op == 3'd2) && mwb_dest == s) v = mwb_val;
    if (exm_op == 3'd1 && exm_dest == s) v = exm_val;
    return v;
  endfunction

  // Requirement that decides the expected value.
  function automatic string rule_of(input logic [RW-1:0] s);
    int nprod = 0;
    bit ign = 1'b0;
    if (exm_op == 3'd1 && exm_dest == s) nprod++;
    if ((mwb_op == 3'd1 || mwb_op == 3'd2) && mwb_dest == s) nprod++;
    if ((wbh_op == 3'd1 || wbh_op == 3'd2) && wbh_dest == s) nprod++;
    if ((exm_op == 3'd0 || exm_op > 3'd2) && exm_dest == s) ign = 1'b1;
    if ((mwb_op == 3'd0 || mwb_op > 3'd2) && mwb_dest == s) ign = 1'b1;
    if ((wbh_op == 3'd0 || wbh_op > 3'd2) && wbh_dest == s) ign = 1'b1;
    if (nprod > 1) return "R6";
    if (exm_op == 3'd2 && exm_dest == s) return "R3";
    if (exm_op == 3'd1 && exm_dest == s) return "R2";
    if (nprod == 1 && (mwb_op == 3'd1 || mwb_op == 3'd2) && mwb_dest == s) return "R4";
    if (nprod == 1) return "R5";
    if (ign) return "R7";
    return "R1";
  endfunction

  task automatic check(input string tag, input string which,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s operand %s: actual %h expected %h", tag, which, act, exp);
    end
  endtask

  task automatic check_all;
    check(rule_of(src_a), "a", opnd_a, model(src_a, rf_a));
    check({"R8 ", rule_of(src_b)}, "b", opnd_b, model(src_b, rf_b));
    check({"R8 ", rule_of(src_sd)}, "sd", store_data, model(src_sd, rf_sd));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset-like idle state: all slots empty, operands from the file (R1).
    @(negedge clk);
    check("R1", "a", opnd_a, 32'h0);
    rf_a = 32'h1111_0001; rf_b = 32'h2222_0002; rf_sd = 32'h3333_0003;
    exm_val = 32'hE0E0_0010; mwb_val = 32'hA5A5_0020; wbh_val = 32'h7B7B_0030;

    // R9: outputs track a change with no clock edge in between.
    @(posedge clk);
    exm_op = 3'd1; exm_dest = 3'd2; src_a = 3'd2;
    #1;
    check("R9", "a", opnd_a, 32'hE0E0_0010);
    exm_op = 3'd2;
    #1;
    check("R9", "a", opnd_a, 32'h1111_0001);

    // Full sweep of opcode classes, destinations and specifiers.
    for (int o0 = 0; o0 < 5; o0++)
      for (int o1 = 0; o1 < 5; o1++)
        for (int o2 = 0; o2 < 5; o2++)
          for (int d0 = 0; d0 < 4; d0++)
            for (int d1 = 0; d1 < 4; d1++)
              for (int d2 = 0; d2 < 4; d2++)
                for (int k = 0; k < 4; k++) begin
                  @(posedge clk);
                  exm_op = 3'(o0); mwb_op = 3'(o1); wbh_op = 3'(o2);
                  exm_dest = RW'(d0); mwb_dest = RW'(d1); wbh_dest = RW'(d2);
                  src_a = RW'(k); src_b = RW'((k + 1) % 4); src_sd = RW'((k + 2) % 4);
                  @(negedge clk);
                  check_all();
                end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule